// File: doc/BRIEF.md
# DMA Abort Recovery Sequencer

This block takes a transmit DMA engine from an abort request back to a clean state from which it can be restarted. Once an abort is accepted, the sequencer first waits for the engine to report that it has been disabled. A cycle-count timeout replaces that report if it never comes. The sequencer then waits for the engine's hardware status to show it is idle. That wait has a bounded number of retries, and the sequencer carries on when the retries are used up.

Next comes a single cleanup cycle. In it, the sequencer strobes a flush of every active request with aborted status, a clear of the ring pointers, and a rewrite of the length/generation register. The DMA enable is then dropped.

If the link is up and the engine is marked running, the sequencer restarts the engine in the same pass. It clears its sticky flags, holds the enable low for one cycle, issues a restart pulse, and then raises the enable, because the engine arms only on a rising enable. If the link is not up, the sequencer parks in the idle state with the aborting flag still set. It restarts as soon as the link and running conditions both hold. A shutdown input freezes the whole sequencer.

Top module: `dma_abort_recovery`

## Requirements
- R1: After reset, abort_status_o is 0 (none), dma_enable_o, aborting_o and disabled_o are 0, and no strobe is asserted.
- R2: In the idle state, with shutdown low, abort_req_i moves abort_status_o to 1 (disarmed) on the next cycle and sets aborting_o. An abort request seen in any other state is ignored and does not restart the timeout.
- R3: In the disarmed state, disabled_irq_i moves abort_status_o to 2 (aborted) on the next cycle and sets disabled_o.
- R4: If no disabled report arrives, the sequencer stays disarmed for exactly TIMEOUT_CYC cycles. It then moves to aborted and sets disabled_o.
- R5: In the aborted state, the engine counts as quiescent only when drain-busy, abort-busy and internal-enable are all low and scoreboard-empty is high. A quiescent cycle leads to cleanup on the next cycle.
- R6: While the engine is not quiescent, the sequencer spends one cycle per retry. After RETRY_MAX retries (RETRY_MAX+1 cycles in aborted) it proceeds to cleanup regardless.
- R7: Cleanup is a single cycle. In it, flush_active_o, clear_ptrs_o and lengen_wr_o are all high, and lengen_data_o carries RING_DEPTH in bits 17:0 with bit 18 set (0x00040100 for depth 256).
- R8: dma_enable_o is low from the cycle after the cleanup strobe.
- R9: When link_active_i and running_i are both high after cleanup, the sequencer proceeds as follows. aborting_o and disabled_o clear, and the enable stays low for one cycle. restart_o then pulses three cycles after the cleanup strobe, and dma_enable_o rises the cycle after the pulse. abort_status_o is then 0.
- R10: When link_active_i or running_i is low after cleanup, no restart is issued. The sequencer returns to status 0 with aborting_o still set. It later restarts (restart_o two cycles after both conditions are seen high) without a new abort.
- R11: While shutdown_i is high, the state, the timeout count and the retry count hold, and no strobe or restart is issued. Abort requests and disabled reports seen in that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_req_i | input | 1 | Request to abort the DMA engine |
| disabled_irq_i | input | 1 | Engine reports it has been disabled |
| hw_drain_busy_i | input | 1 | Engine scoreboard drain in progress |
| hw_abort_busy_i | input | 1 | Engine abort in progress |
| hw_int_enable_i | input | 1 | Engine internal enable still set |
| hw_scb_empty_i | input | 1 | Engine scoreboard empty |
| link_active_i | input | 1 | Link is active |
| running_i | input | 1 | Engine is configured and not torn down |
| shutdown_i | input | 1 | Freezes all sequencer activity |
| flush_active_o | output | 1 | Flush all active requests as aborted |
| clear_ptrs_o | output | 1 | Clear head, tail, generation and head write-back; set removed count to added count |
| lengen_wr_o | output | 1 | Write strobe for the length/generation register |
| lengen_data_o | output | 32 | Value for the length/generation register (zero when not writing) |
| dma_enable_o | output | 1 | DMA enable level |
| restart_o | output | 1 | One-cycle restart pulse |
| abort_status_o | output | 2 | 0 none, 1 disarmed, 2 aborted |
| aborting_o | output | 1 | Sticky aborting flag |
| disabled_o | output | 1 | Sticky disabled flag |

## Verification
The recovery path is driven in several ways, and each run predicts the exact cycle of the cleanup strobe and of the restart pulse.

- **Early disabled report vs. silent timeout.** One run sends an early disabled report; another sends none. Comparing them separates the interrupt exit from the timeout exit, and a stray abort request during the wait shows whether the timeout gets restarted.
- **Not-quiescent causes.** Each of the four causes is held alone for two cycles. This shows whether every status bit enters the quiescence test. A cause held throughout shows whether the retry budget runs out on the predicted cycle.
- **Blocked and deferred restart.** Runs with the link down or running low show that no restart is issued, and that the deferred restart follows later.
- **Shutdown.** Shutdown held across the wait, with a disabled report arriving inside it, shows that the timeout count freezes rather than resets.

// File: rtl/arc_pkg.sv
package arc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DISARMED = 3'd1,
    ST_ABORTED  = 3'd2,
    ST_CLEANUP  = 3'd3,
    ST_DISABLE  = 3'd4,
    ST_RST_LO   = 3'd5,
    ST_RST_HI   = 3'd6
  } seq_state_e;

  localparam logic [1:0] AB_NONE     = 2'd0;
  localparam logic [1:0] AB_DISARMED = 2'd1;
  localparam logic [1:0] AB_ABORTED  = 2'd2;

  localparam int GEN_CHECK_BIT = 18;

  // Engine is idle only with every busy indication low and the scoreboard empty
  function automatic logic engine_quiet(input logic drain, input logic abt,
                                        input logic inten, input logic scb_empty);
    return !drain && !abt && !inten && scb_empty;
  endfunction

  // Ring depth in the low field, generation checking enabled above it
  function automatic logic [31:0] lengen_word(input int unsigned depth);
    logic [31:0] w;
    w = '0;
    w[GEN_CHECK_BIT-1:0] = depth[GEN_CHECK_BIT-1:0];
    w[GEN_CHECK_BIT] = 1'b1;
    return w;
  endfunction

  function automatic logic [1:0] status_of(input seq_state_e s);
    case (s)
      ST_DISARMED:                        return AB_DISARMED;
      ST_ABORTED, ST_CLEANUP, ST_DISABLE: return AB_ABORTED;
      default:                            return AB_NONE;
    endcase
  endfunction

endpackage

// File: rtl/arc_cycle_timer.sv
module arc_cycle_timer #(
  parameter int LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign expired_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (run_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

  // R4
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R11
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/arc_retry_budget.sv
module arc_retry_budget #(
  parameter int MAX = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic step_i,
  output logic empty_o
);
  localparam int W = (MAX < 1) ? 1 : $clog2(MAX + 1);
  localparam logic [W-1:0] TOP = W'(MAX);

  logic [W-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= TOP;
    else if (load_i)             cnt_q <= TOP;
    else if (step_i && !empty_o) cnt_q <= cnt_q - 1'b1;
  end

  // R6
  budget_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);

endmodule

// File: rtl/arc_flag_bank.sv
module arc_flag_bank (
  input  logic clk,
  input  logic rst_n,
  input  logic set_abort_i,
  input  logic set_dis_i,
  input  logic clr_flags_i,
  input  logic en_drop_i,
  input  logic en_raise_i,
  output logic aborting_o,
  output logic disabled_o,
  output logic enable_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aborting_o <= 1'b0;
      disabled_o <= 1'b0;
      enable_o   <= 1'b0;
    end else begin
      if (clr_flags_i) begin
        aborting_o <= 1'b0;
        disabled_o <= 1'b0;
      end else begin
        if (set_abort_i) aborting_o <= 1'b1;
        if (set_dis_i)   disabled_o <= 1'b1;
      end
      if (en_drop_i)       enable_o <= 1'b0;
      else if (en_raise_i) enable_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_abort_recovery.sv
module dma_abort_recovery
  import arc_pkg::*;
#(
  parameter int RING_DEPTH  = 256,
  parameter int TIMEOUT_CYC = 20,
  parameter int RETRY_MAX   = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        abort_req_i,
  input  logic        disabled_irq_i,
  input  logic        hw_drain_busy_i,
  input  logic        hw_abort_busy_i,
  input  logic        hw_int_enable_i,
  input  logic        hw_scb_empty_i,
  input  logic        link_active_i,
  input  logic        running_i,
  input  logic        shutdown_i,
  output logic        flush_active_o,
  output logic        clear_ptrs_o,
  output logic        lengen_wr_o,
  output logic [31:0] lengen_data_o,
  output logic        dma_enable_o,
  output logic        restart_o,
  output logic [1:0]  abort_status_o,
  output logic        aborting_o,
  output logic        disabled_o
);
  localparam logic [31:0] LENGEN_VAL = lengen_word(RING_DEPTH);

  seq_state_e st_q, st_d;

  // named internal events
  logic act, quiet, may_restart, wait_expired, budget_empty;
  logic ev_cleanup, ev_restart, ev_set_abort, ev_set_dis, ev_clr_flags, ev_drop, ev_raise;

  assign act         = !shutdown_i;
  assign quiet       = engine_quiet(hw_drain_busy_i, hw_abort_busy_i,
                                    hw_int_enable_i, hw_scb_empty_i);
  assign may_restart = link_active_i && running_i;

  always_comb begin
    st_d = st_q;
    if (act) begin
      case (st_q)
        ST_IDLE: begin
          if (abort_req_i)                     st_d = ST_DISARMED;
          else if (aborting_o && may_restart)  st_d = ST_RST_LO;
        end
        ST_DISARMED: if (disabled_irq_i || wait_expired) st_d = ST_ABORTED;
        ST_ABORTED:  if (quiet || budget_empty)          st_d = ST_CLEANUP;
        ST_CLEANUP:  st_d = ST_DISABLE;
        ST_DISABLE:  st_d = may_restart ? ST_RST_LO : ST_IDLE;
        ST_RST_LO:   st_d = ST_RST_HI;
        ST_RST_HI:   st_d = ST_IDLE;
        default:     st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign ev_cleanup   = act && (st_q == ST_CLEANUP);
  assign ev_restart   = act && (st_q == ST_RST_HI);
  assign ev_set_abort = act && (st_q == ST_IDLE) && abort_req_i;
  assign ev_set_dis   = act && (st_q == ST_DISARMED) && (st_d == ST_ABORTED);
  assign ev_clr_flags = act && (st_d == ST_RST_LO) && (st_q != ST_RST_LO);
  assign ev_drop      = ev_cleanup || ev_clr_flags;
  assign ev_raise     = ev_restart;

  arc_cycle_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (st_q != ST_DISARMED),
    .run_i     (act && (st_q == ST_DISARMED)),
    .expired_o (wait_expired)
  );

  arc_retry_budget #(.MAX(RETRY_MAX)) u_budget (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (st_q != ST_ABORTED),
    .step_i  (act && (st_q == ST_ABORTED) && !quiet),
    .empty_o (budget_empty)
  );

  arc_flag_bank u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_abort_i (ev_set_abort),
    .set_dis_i   (ev_set_dis),
    .clr_flags_i (ev_clr_flags),
    .en_drop_i   (ev_drop),
    .en_raise_i  (ev_raise),
    .aborting_o  (aborting_o),
    .disabled_o  (disabled_o),
    .enable_o    (dma_enable_o)
  );

  assign flush_active_o = ev_cleanup;
  assign clear_ptrs_o   = ev_cleanup;
  assign lengen_wr_o    = ev_cleanup;
  assign lengen_data_o  = ev_cleanup ? LENGEN_VAL : 32'd0;
  assign restart_o      = ev_restart;
  assign abort_status_o = status_of(st_q);

  // R2
  abort_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && abort_req_i && !shutdown_i) |=> (abort_status_o == AB_DISARMED && aborting_o));

  // R7
  cleanup_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_active_o |=> !flush_active_o);

  // R8
  enable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_active_o |=> !dma_enable_o);

  // R9
  restart_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> dma_enable_o);

  // R9
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> (!aborting_o && !disabled_o && !dma_enable_o));

  // R10
  no_link_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DISABLE && !shutdown_i && !may_restart) |=> (st_q == ST_IDLE && aborting_o));

  // R11
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_i |=> $stable(st_q));

  // R11
  silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_i |-> (!flush_active_o && !lengen_wr_o && !restart_o));

endmodule

// File: tb/dma_abort_recovery_tb.sv
module dma_abort_recovery_tb;
  localparam int DEPTH = 256;
  localparam int TO    = 20;
  localparam int RM    = 6;
  localparam logic [31:0] LG_EXP = 32'h0004_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic abort_req = 0, irq = 0, drain = 0, abt = 0, inten = 0, scb = 1;
  logic link = 1, running = 1, shutdown = 0;
  logic flush, clrp, lgwr, den, rstp, aborting, disabled;
  logic [31:0] lgdata;
  logic [1:0]  status;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct { int kind; int at; string tag; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_abort_recovery #(.RING_DEPTH(DEPTH), .TIMEOUT_CYC(TO), .RETRY_MAX(RM)) u_dut (
    .clk(clk), .rst_n(rst_n), .abort_req_i(abort_req), .disabled_irq_i(irq),
    .hw_drain_busy_i(drain), .hw_abort_busy_i(abt), .hw_int_enable_i(inten),
    .hw_scb_empty_i(scb), .link_active_i(link), .running_i(running),
    .shutdown_i(shutdown), .flush_active_o(flush), .clear_ptrs_o(clrp),
    .lengen_wr_o(lgwr), .lengen_data_o(lgdata), .dma_enable_o(den),
    .restart_o(rstp), .abort_status_o(status), .aborting_o(aborting),
    .disabled_o(disabled)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, expv);
    end
  endtask

  task automatic push(input int kind, input int at, input string tag);
    exp_t e;
    e.kind = kind; e.at = at; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic pop_cmp(input int kind);
    exp_t e;
    if (q.size() == 0) begin
      chk(0, (kind == 0) ? "R7 unexpected cleanup" : "R10 unexpected restart", cyc, -1);
    end else begin
      e = q.pop_front();
      chk(e.kind == kind, e.tag, kind, e.kind);
      chk(e.at == cyc, e.tag, cyc, e.at);
    end
  endtask

  // monitor: samples after the driver has settled inputs at the falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (flush) begin
        chk(clrp && lgwr, "R7 strobes together", {clrp, lgwr}, 3);
        chk(lgdata == LG_EXP, "R7 lengen value", lgdata, LG_EXP);
        pop_cmp(0);
      end
      if (rstp) pop_cmp(1);
    end
  end

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic status_chk(input string tag, input int st);
    chk(status == st[1:0], tag, status, st);
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog expired: actual cycle %0d expected below 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n0;
    int m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    status_chk("R1 status", 0);
    chk(!den, "R1 enable", den, 0);
    chk(!aborting && !disabled, "R1 flags", {aborting, disabled}, 0);
    chk(!flush && !rstp && !lgwr, "R1 strobes", {flush, rstp, lgwr}, 0);

    // A: early disabled report, quiet engine, restart
    @(negedge clk); n0 = cyc;
    push(0, n0 + 5, "R3 cleanup after report"); push(1, n0 + 8, "R9 restart timing");
    abort_req = 1;
    wait_to(n0 + 1); abort_req = 0;
    status_chk("R2 disarmed", 1);
    chk(aborting, "R2 aborting set", aborting, 1);
    wait_to(n0 + 3); irq = 1;
    wait_to(n0 + 4); irq = 0;
    status_chk("R3 aborted", 2);
    chk(disabled, "R3 disabled set", disabled, 1);
    wait_to(n0 + 7); chk(!den, "R9 enable low before pulse", den, 0);
    wait_to(n0 + 9);
    chk(den, "R9 enable high", den, 1);
    status_chk("R9 status none", 0);
    chk(!aborting && !disabled, "R9 flags cleared", {aborting, disabled}, 0);

    // B: timeout path, stray abort ignored
    @(negedge clk); n0 = cyc;
    push(0, n0 + TO + 2, "R4 cleanup after timeout"); push(1, n0 + TO + 5, "R9 restart after timeout");
    abort_req = 1;
    wait_to(n0 + 1); abort_req = 0;
    wait_to(n0 + 5); abort_req = 1;
    wait_to(n0 + 6); abort_req = 0;
    status_chk("R2 stray abort ignored", 1);
    wait_to(n0 + TO); status_chk("R4 still disarmed", 1);
    chk(!disabled, "R4 disabled not yet", disabled, 0);
    wait_to(n0 + TO + 1); status_chk("R4 aborted on timeout", 2);
    chk(disabled, "R4 disabled on timeout", disabled, 1);
    wait_to(n0 + TO + 2); chk(den, "R8 enable before drop", den, 1);
    wait_to(n0 + TO + 3); chk(!den, "R8 enable dropped", den, 0);
    wait_to(n0 + TO + 6); chk(den, "R9 enable re-armed", den, 1);

    // C: never quiescent, link down, deferred restart
    @(negedge clk); link = 0; drain = 1; n0 = cyc;
    push(0, n0 + RM + 3, "R6 cleanup after retries");
    abort_req = 1;
    wait_to(n0 + 1); abort_req = 0; irq = 1;
    wait_to(n0 + 2); irq = 0; status_chk("R3 aborted", 2);
    wait_to(n0 + RM + 2); status_chk("R6 retrying", 2);
    wait_to(n0 + RM + 5);
    status_chk("R10 parked none", 0);
    chk(aborting, "R10 aborting kept", aborting, 1);
    chk(!den, "R10 enable low", den, 0);
    drain = 0;
    wait_to(n0 + RM + 9); chk(aborting && !den, "R10 no restart while link down", {aborting, den}, 2);
    m = cyc; link = 1;
    push(1, m + 2, "R10 deferred restart");
    wait_to(m + 1); chk(!aborting, "R9 flags cleared on deferred", aborting, 0);
    wait_to(m + 3); chk(den, "R10 enable after deferred", den, 1);

    // D: each non-quiescent cause held two retry cycles
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); n0 = cyc;
      case (k)
        0: drain = 1;
        1: abt = 1;
        2: inten = 1;
        default: scb = 0;
      endcase
      push(0, n0 + 5, "R5 cleanup after cause clears"); push(1, n0 + 8, "R9 restart");
      abort_req = 1;
      wait_to(n0 + 1); abort_req = 0; irq = 1;
      wait_to(n0 + 2); irq = 0;
      wait_to(n0 + 4); status_chk("R5 busy holds aborted", 2);
      drain = 0; abt = 0; inten = 0; scb = 1;
      wait_to(n0 + 9); chk(den, "R5 enable after recovery", den, 1);
    end

    // E: running low blocks restart
    @(negedge clk); running = 0; n0 = cyc;
    push(0, n0 + 3, "R5 quiet cleanup");
    abort_req = 1;
    wait_to(n0 + 1); abort_req = 0; irq = 1;
    wait_to(n0 + 2); irq = 0;
    wait_to(n0 + 8);
    status_chk("R10 none without running", 0);
    chk(aborting && !den, "R10 no restart without running", {aborting, den}, 2);
    m = cyc; running = 1;
    push(1, m + 2, "R10 restart once running");
    wait_to(m + 3); chk(den, "R10 enable once running", den, 1);

    // F: shutdown freezes the timeout
    @(negedge clk); n0 = cyc;
    abort_req = 1;
    wait_to(n0 + 1); abort_req = 0;
    wait_to(n0 + 3); shutdown = 1;
    wait_to(n0 + 10); irq = 1;
    wait_to(n0 + 11); irq = 0;
    status_chk("R11 report ignored in shutdown", 1);
    chk(!disabled, "R11 disabled untouched", disabled, 0);
    wait_to(n0 + 43); shutdown = 0;
    push(0, n0 + TO + 42, "R11 cleanup after frozen wait"); push(1, n0 + TO + 45, "R11 restart after frozen wait");
    wait_to(n0 + TO + 40); status_chk("R11 timer held", 1);
    wait_to(n0 + TO + 41); status_chk("R11 timeout resumes", 2);
    wait_to(n0 + TO + 46); chk(den, "R11 enable after recovery", den, 1);

    // G: abort request during shutdown in idle
    @(negedge clk); shutdown = 1; abort_req = 1;
    @(negedge clk); @(negedge clk);
    status_chk("R11 abort ignored", 0);
    shutdown = 0; abort_req = 0;
    @(negedge clk);
    status_chk("R11 still idle", 0);
    chk(!aborting && den, "R11 flags untouched", {aborting, den}, 1);

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R9 all expected events seen", q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule